// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Interval Generator

This block produces the serial clock and the chip-select timing of one SPI frame for a frame sequencer. The timing comes from a functional clock and one 24-bit attribute word. The sequencer supplies four things: the clock polarity, the number of clock periods in the frame, a one-cycle start request and a continue flag. The block then drives three steps in turn. It asserts chip-select and waits a lead interval. It generates the clock edges, marking each leading edge and each trailing edge with a one-cycle strobe. Unless continue was set, it then waits an after-clock interval, negates chip-select and waits a gap interval before it reports completion. Shifting the data bits is left to the sequencer, which uses the strobes.

Every divider is a product of a prescaler table entry and a scaler table entry. They are not plain binary counts. The attribute word, the polarity, the frame length and the continue flag are captured when a start is accepted. Changes made while a frame runs wait for the next frame.

Top module: `spi_tgen`

## Requirements
- R1: During reset and after it, while no frame is running, `cs_active`, `busy`, `done`, `lead_stb` and `trail_stb` are 0. While idle, `sck` equals `cpol` with one cycle of register delay.
- R2: The baud prescaler `attr[17:16]` codes 0..3 select 2, 3, 5 and 7. The baud scaler `attr[3:0]` codes 0..15 select 2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048, 4096, 8192, 16384 and 32768. Their product is the clock period in functional clocks, and consecutive clock edges are half a period apart.
- R3: A start accepted while chip-select is negated raises `cs_active` on the accepting edge. The first clock edge follows a lead interval later. That interval is the delay prescaler `attr[23:22]` (codes 0..3 give 1, 3, 5, 7) times 2^(n+1), where n is the scaler `attr[15:12]`.
- R4: Without continue, `cs_active` falls a fixed time after the last clock edge. That time is the prescaler `attr[21:20]` times 2^(n+1), with n = `attr[11:8]`, using the same code tables as R3.
- R5: After chip-select falls, `done` pulses for one cycle a gap later. The gap is the prescaler `attr[19:18]` times 2^(n+1), with n = `attr[7:4]`. `busy` drops in the same cycle, and a new start is accepted from then on.
- R6: A frame of `nbits` (at least 1) periods makes 2·`nbits` clock edges. The edges alternate between leading (away from `cpol`, marked by `lead_stb`) and trailing (back to `cpol`, marked by `trail_stb`). The frame always ends at the idle level.
- R7: When continue is captured high, chip-select stays asserted after the frame. `done` pulses in the cycle of the last clock edge, and the after-clock and gap intervals are skipped.
- R8: A start accepted while chip-select is still asserted from a continued frame skips the lead interval. The first clock edge comes one cycle after the accepting edge.
- R9: Changes to `attr`, `cpol`, `nbits` and `cont` while `busy` is high do not alter the running frame.
- R10: A start while `busy` is high is ignored and produces no extra edges or chip-select activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attr | input | 24 | Attribute word: divider codes (layout in R2 to R5) |
| cpol | input | 1 | Clock idle level |
| nbits | input | NB_W | Clock periods per frame, 1 or more |
| start | input | 1 | Frame start request, taken while idle |
| cont | input | 1 | Keep chip-select asserted after this frame |
| sck | output | 1 | Serial clock |
| cs_active | output | 1 | Chip-select asserted (high active) |
| lead_stb | output | 1 | Pulses with each leading clock edge |
| trail_stb | output | 1 | Pulses with each trailing clock edge |
| done | output | 1 | One-cycle pulse when the frame and its intervals end |
| busy | output | 1 | Frame in progress |

## Verification
The assertions take for granted that a start accepted in idle carries a nonzero `nbits`. They also assume the sequencer does not expect a start raised during a frame to be queued. The stimulus always gives frame lengths from 1 to 63. Its only start during a busy frame is a deliberate disturbance, which comes together with changed attribute, polarity, length and continue inputs. Strobe sense and chip-select behaviour are checked against the polarity and continue flag captured at the start of the frame, which is how the stimulus defines them.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;
   typedef enum logic [2:0] {
      TG_IDLE,
      TG_LEAD,
      TG_CLK,
      TG_TRAIL,
      TG_GAP
   } tg_state_e;

   localparam int TG_ATTR_W   = 24;
   localparam int TG_NDLY     = 3;
   localparam int TG_DLY_LEAD = 0;
   localparam int TG_DLY_AFT  = 1;
   localparam int TG_DLY_GAP  = 2;
   // widest interval: 7 * 2^16 functional clocks
   localparam int TG_MIN_CW   = 19;
endpackage

// File: rtl/spi_tgen_baud.sv
module spi_tgen_baud #(
   parameter int CNT_W = 19
) (
   input  logic [1:0]       pre_code,
   input  logic [3:0]       scl_code,
   output logic [CNT_W-1:0] half_len
);
   logic [2:0]       pre;
   logic [CNT_W-1:0] half_scl;

   always_comb begin
      case (pre_code)
         2'd0:    pre = 3'd2;
         2'd1:    pre = 3'd3;
         2'd2:    pre = 3'd5;
         default: pre = 3'd7;
      endcase
   end

   // half of the scaler: 1,2,3 then powers of two
   always_comb begin
      if (scl_code < 4'd3)
         half_scl = CNT_W'(scl_code) + CNT_W'(1);
      else
         half_scl = CNT_W'(1) << (scl_code - 4'd1);
   end

   assign half_len = CNT_W'(pre) * half_scl;
endmodule

// File: rtl/spi_tgen_dly.sv
module spi_tgen_dly #(
   parameter int CNT_W = 19
) (
   input  logic [1:0]       pre_code,
   input  logic [3:0]       scl_code,
   output logic [CNT_W-1:0] len
);
   // prescaler 1,3,5,7 is 2*code+1; scaler is 2^(n+1)
   assign len = CNT_W'({pre_code, 1'b1}) << ({1'b0, scl_code} + 5'd1);
endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
   import spi_tgen_pkg::*;
#(
   parameter int NB_W  = 6,
   parameter int CNT_W = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TG_ATTR_W-1:0] attr,
   input  logic                 cpol,
   input  logic [NB_W-1:0]      nbits,
   input  logic                 start,
   input  logic                 cont,
   output logic                 sck,
   output logic                 cs_active,
   output logic                 lead_stb,
   output logic                 trail_stb,
   output logic                 done,
   output logic                 busy
);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [NB_W:0]    EDGE_ONE = (NB_W+1)'(1);

   if (CNT_W < TG_MIN_CW) begin : g_cnt_chk
      $error("spi_tgen: CNT_W too small for the longest interval");
   end
   if (NB_W < 1) begin : g_nb_chk
      $error("spi_tgen: NB_W must be at least 1");
   end

   logic [CNT_W-1:0] half_live;
   logic [CNT_W-1:0] dly_len [TG_NDLY];

   spi_tgen_baud #(.CNT_W(CNT_W)) u_baud (
      .pre_code (attr[17:16]),
      .scl_code (attr[3:0]),
      .half_len (half_live)
   );

   for (genvar g = 0; g < TG_NDLY; g++) begin : g_dly
      spi_tgen_dly #(.CNT_W(CNT_W)) u_dly (
         .pre_code (attr[23-2*g -: 2]),
         .scl_code (attr[15-4*g -: 4]),
         .len      (dly_len[g])
      );
   end

   tg_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [NB_W:0]    edges_q;
   logic [CNT_W-1:0] half_q, aft_q, gap_q;
   logic             cont_q, cpol_q;
   logic             sck_q, cs_q, lead_q, trail_q, done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TG_IDLE;
         cnt     <= '0;
         edges_q <= '0;
         half_q  <= '0;
         aft_q   <= '0;
         gap_q   <= '0;
         cont_q  <= 1'b0;
         cpol_q  <= 1'b0;
         sck_q   <= 1'b0;
         cs_q    <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         done_q  <= 1'b0;
         case (state)
            TG_IDLE: begin
               sck_q <= cpol;
               if (start) begin
                  cpol_q  <= cpol;
                  cont_q  <= cont;
                  half_q  <= half_live;
                  aft_q   <= dly_len[TG_DLY_AFT];
                  gap_q   <= dly_len[TG_DLY_GAP];
                  edges_q <= {nbits, 1'b0};
                  cs_q    <= 1'b1;
                  cnt     <= cs_q ? '0 : dly_len[TG_DLY_LEAD] - CNT_ONE;
                  state   <= TG_LEAD;
               end
            end
            TG_LEAD: begin
               if (cnt == '0) begin
                  sck_q   <= ~sck_q;
                  lead_q  <= 1'b1;
                  edges_q <= edges_q - EDGE_ONE;
                  cnt     <= half_q - CNT_ONE;
                  state   <= TG_CLK;
               end else begin
                  cnt <= cnt - CNT_ONE;
               end
            end
            TG_CLK: begin
               if (cnt == '0) begin
                  sck_q <= ~sck_q;
                  if (sck_q == cpol_q) lead_q <= 1'b1;
                  else                 trail_q <= 1'b1;
                  edges_q <= edges_q - EDGE_ONE;
                  if (edges_q == EDGE_ONE) begin
                     if (cont_q) begin
                        done_q <= 1'b1;
                        state  <= TG_IDLE;
                     end else begin
                        cnt   <= aft_q - CNT_ONE;
                        state <= TG_TRAIL;
                     end
                  end else begin
                     cnt <= half_q - CNT_ONE;
                  end
               end else begin
                  cnt <= cnt - CNT_ONE;
               end
            end
            TG_TRAIL: begin
               if (cnt == '0) begin
                  cs_q  <= 1'b0;
                  cnt   <= gap_q - CNT_ONE;
                  state <= TG_GAP;
               end else begin
                  cnt <= cnt - CNT_ONE;
               end
            end
            TG_GAP: begin
               if (cnt == '0) begin
                  done_q <= 1'b1;
                  state  <= TG_IDLE;
               end else begin
                  cnt <= cnt - CNT_ONE;
               end
            end
            default: state <= TG_IDLE;
         endcase
      end
   end

   assign sck       = sck_q;
   assign cs_active = cs_q;
   assign lead_stb  = lead_q;
   assign trail_stb = trail_q;
   assign done      = done_q;
   assign busy      = (state != TG_IDLE);

   // R6
   lead_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_q |-> (sck_q != cpol_q));
   // R6
   trail_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_q |-> (sck_q == cpol_q));
   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead_q, trail_q}));
   // R6
   nbits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == TG_IDLE) |-> (nbits != '0));
   // R3
   cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_q) |-> (state == TG_LEAD));
   // R4
   cs_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_q) |-> (sck_q == cpol_q));
   // R7
   cs_fall_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_q) |-> !cont_q);
   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state == TG_IDLE));
   // R9
   hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != TG_IDLE) |=> ($stable(half_q) && $stable(cpol_q) && $stable(cont_q)));
endmodule

// File: tb/sim_spi_tgen.sv
`timescale 1ns/1ps
module sim_spi_tgen;
   localparam int NB_W = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [23:0]     attr = '0;
   logic            cpol = 1'b0;
   logic [NB_W-1:0] nbits = 6'd1;
   logic            start = 1'b0;
   logic            cont = 1'b0;
   logic            sck, cs_active, lead_stb, trail_stb, done, busy;

   always #2 clk = ~clk;

   spi_tgen #(.NB_W(NB_W), .CNT_W(19)) u0 (
      .clk(clk), .rst_n(rst_n), .attr(attr), .cpol(cpol), .nbits(nbits),
      .start(start), .cont(cont), .sck(sck), .cs_active(cs_active),
      .lead_stb(lead_stb), .trail_stb(trail_stb), .done(done), .busy(busy)
   );

   typedef struct {
      int    kind;
      int    cyc;
      string tag;
   } ev_t;

   ev_t   q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   bit    cur_cpol = 1'b0;
   bit    cs_model = 1'b0;
   bit    prev_cs = 1'b0;
   string kname [5] = '{"cs_rise", "lead_edge", "trail_edge", "cs_fall", "done"};

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int b_pre(int c);
      case (c)
         0: return 2;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int b_scl(int c);
      case (c)
         0: return 2;      1: return 4;      2: return 6;      3: return 8;
         4: return 16;     5: return 32;     6: return 64;     7: return 128;
         8: return 256;    9: return 512;    10: return 1024;  11: return 2048;
         12: return 4096;  13: return 8192;  14: return 16384; default: return 32768;
      endcase
   endfunction

   function automatic int d_len(int p, int s);
      int pv;
      case (p)
         0: pv = 1;
         1: pv = 3;
         2: pv = 5;
         default: pv = 7;
      endcase
      return pv * (1 << (s + 1));
   endfunction

   function automatic logic [23:0] mk(int lp, int ap, int gp, int bp,
                                      int ls, int as_, int gs, int bs);
      logic [23:0] a = '0;
      a[23:22] = 2'(lp); a[21:20] = 2'(ap); a[19:18] = 2'(gp); a[17:16] = 2'(bp);
      a[15:12] = 4'(ls); a[11:8]  = 4'(as_); a[7:4]  = 4'(gs); a[3:0]   = 4'(bs);
      return a;
   endfunction

   function automatic void push(int k, int c, string t);
      ev_t e;
      e.kind = k; e.cyc = c; e.tag = t;
      q.push_back(e);
   endfunction

   task automatic see(int kind);
      ev_t e;
      checks++;
      if (q.size() == 0) begin
         errors++;
         $display("FAIL R10 unexpected %s actual=%0d expected=none", kname[kind], cyc);
      end else begin
         e = q.pop_front();
         if (e.kind != kind || e.cyc != cyc) begin
            errors++;
            $display("FAIL %s %s at cycle actual=%0d(%s) expected=%0d(%s)",
                     e.tag, kname[e.kind], cyc, kname[kind], e.cyc, kname[e.kind]);
         end
      end
   endtask

   // monitor: observes the ports away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_active && !prev_cs) see(0);
         if (lead_stb) begin
            see(1);
            chk(sck != cur_cpol, "R6", "sck after leading edge", sck, !cur_cpol);
         end
         if (trail_stb) begin
            see(2);
            chk(sck == cur_cpol, "R6", "sck after trailing edge", sck, cur_cpol);
         end
         if (!cs_active && prev_cs) see(3);
         if (done) see(4);
      end
      prev_cs = cs_active;
   end

   // driver: starts one frame and queues the events it must produce
   task automatic frame(logic [23:0] a, int n, bit c, bit p, bit disturb);
      int h, lead, aft, gap, e0, el, l;
      string ftag;
      @(negedge clk);
      attr = a; nbits = NB_W'(n); cont = c; cpol = p; start = 1'b1;
      cur_cpol = p;
      e0   = cyc + 1;
      h    = b_pre(int'(a[17:16])) * b_scl(int'(a[3:0])) / 2;
      lead = d_len(int'(a[23:22]), int'(a[15:12]));
      aft  = d_len(int'(a[21:20]), int'(a[11:8]));
      gap  = d_len(int'(a[19:18]), int'(a[7:4]));
      if (!cs_model) push(0, e0, "R3");
      l    = cs_model ? 1 : lead;
      ftag = cs_model ? "R8" : "R3";
      for (int k = 0; k < 2 * n; k++)
         push((k % 2) ? 2 : 1, e0 + l + k * h, (k == 0) ? ftag : "R2");
      el = e0 + l + (2 * n - 1) * h;
      if (c) begin
         push(4, el, "R7");
         cs_model = 1'b1;
      end else begin
         push(3, el + aft, "R4");
         push(4, el + aft + gap, "R5");
         cs_model = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         repeat (3) @(negedge clk);
         chk(busy == 1'b1, "R10", "busy during frame", busy, 1);
         // R9 R10: change everything and raise start mid-frame
         attr = ~a; cpol = !p; nbits = 6'd7; cont = 1'b1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      do @(negedge clk); while (!done);
      @(negedge clk);
      chk(q.size() == 0, c ? "R7" : "R5", "events left after done", q.size(), 0);
      chk(busy == 1'b0, "R5", "busy after done", busy, 0);
      chk(cs_active == c, c ? "R7" : "R4", "chip-select after done", cs_active, c);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_active == 0, "R1", "cs_active in reset", cs_active, 0);
      chk(busy == 0,      "R1", "busy in reset", busy, 0);
      chk(done == 0,      "R1", "done in reset", done, 0);
      chk(sck == 0,       "R1", "sck in reset", sck, 0);
      chk(lead_stb == 0 && trail_stb == 0, "R1", "strobes in reset", lead_stb + trail_stb, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      cpol = 1'b1;
      repeat (2) @(negedge clk);
      chk(sck == 1, "R1", "idle sck follows cpol=1", sck, 1);
      cpol = 1'b0;
      repeat (2) @(negedge clk);
      chk(sck == 0, "R1", "idle sck follows cpol=0", sck, 0);

      // R2 R3 R4 R5 R6: shortest dividers, three periods
      frame(mk(0, 1, 0, 0, 0, 0, 1, 0), 3, 1'b0, 1'b0, 1'b0);
      // R6 with idle-high clock and odd prescalers
      frame(mk(2, 3, 0, 1, 1, 0, 2, 1), 2, 1'b0, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      chk(sck == 1, "R1", "idle sck after idle-high frame", sck, 1);
      // R7 continued frame
      frame(mk(0, 0, 0, 2, 0, 0, 0, 0), 4, 1'b1, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      chk(cs_active == 1, "R7", "chip-select held after continued frame", cs_active, 1);
      // R8 R9 R10: chip-select still asserted, disturbed mid-frame
      frame(mk(1, 1, 1, 0, 1, 1, 1, 1), 2, 1'b0, 1'b0, 1'b1);
      // R2 largest baud scaler, one period
      frame(mk(0, 0, 0, 0, 0, 0, 0, 15), 1, 1'b0, 1'b0, 1'b0);
      // R3 long lead interval
      frame(mk(3, 0, 0, 3, 10, 0, 0, 2), 1, 1'b0, 1'b0, 1'b0);
      // R6 longest frame length
      frame(mk(0, 2, 3, 0, 0, 2, 3, 0), 63, 1'b0, 1'b1, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=%0d expected=done", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule